// File: doc/BRIEF.md
# Box-Mode DMA Command Sequencer

This block walks a linked run of DMA command descriptors held in memory and turns each one into a stream of address beats. Software, or a neighbouring controller, writes the start address of a descriptor list into the command pointer. The sequencer then reads the descriptors one word at a time through a plain request/response memory port, decodes each command, and issues one beat per data word on a valid/ready beat interface. Each beat carries both the source and the destination address of that word.

Two command kinds are handled. A single command is a linear copy of N words. A box command is a two-dimensional copy made of rows. Inside a row both addresses step by one word. Each new row starts at the previous row's start plus a per-side row offset, and an offset of zero holds a peripheral FIFO address fixed. Every row may be held back by a client rate-control request line, picked separately for the source and destination side by fields in the command word. When the last command of the list completes, or when a malformed command is found, a result word is posted for one cycle and the busy flag drops.

Top module: `box_dma_seq`

## Requirements
- R1: After reset, busy, mem_req, beat_valid and result_valid are all low.
- R2: A pointer write while idle starts the list fetch at that byte address and raises busy in the next cycle. Busy stays high until the result is posted. A pointer write while busy is ignored. A pointer whose bits 2:0 are not zero posts an error result at once and fetches nothing.
- R3: Command word bits 2:0 give the type, where 0 is single (4 words: command, source, destination, length) and 3 is box (6 words: command, source, destination, row length, row count, row offset). Bit 31 marks the last command. After a command without bit 31, the next descriptor is fetched from the word that follows it.
- R4: A single command issues length beats. The first beat carries the source and destination addresses, and both addresses rise by 4 on each later beat. A length of zero issues no beats and the list goes on.
- R5: A box command issues rows equal to the source half (bits 31:16) of the row count word, each with beats equal to the source half of the row length word. Inside a row both addresses rise by 4. Each row begins at the previous row's start plus the row offset, where the source offset is in bits 31:16 and the destination offset in bits 15:0.
- R6: Command bits 6:3 select the source rate line and bits 10:7 the destination rate line. Index n from 1 to 15 selects rate_req[n-1], and 0 means no gating. Before each row, including the one row of a single command, no beat is issued until both selected lines are high.
- R7: A beat with valid high and ready low keeps valid high and its addresses unchanged in the next cycle.
- R8: On completion result_word reads 0x80000002, with bit 31 valid and bit 1 list done. result_valid is high for that cycle, and busy is already low in it.
- R9: The error result is 0x80000008, with bit 31 valid and bit 3 error. It is posted, without any beat of the offending command and without fetching further descriptors, in these cases: a box command with a zero source or destination row count, a zero source row length, or source and destination row lengths that differ; a type other than 0 or 3; a single length above 65535; any of command bits 30:11 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_wr | input | 1 | Command pointer write strobe |
| ptr_data | input | AW | Byte address of the first descriptor |
| busy | output | 1 | List in progress |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Descriptor word |
| rate_req | input | NREQ | Client rate-control request lines |
| beat_valid | output | 1 | Beat available |
| beat_ready | input | 1 | Beat accepted |
| beat_src | output | AW | Source word address of the beat |
| beat_dst | output | AW | Destination word address of the beat |
| result_valid | output | 1 | One-cycle result strobe |
| result_word | output | 32 | Result: bit 31 valid, bit 3 error, bit 1 done |

## Verification
A descriptor word captured into the wrong slot, or a stale fetch pointer, shows up as wrong beat addresses on the very first beat of the next command. It can also show as a wrong fetch count when the list ends. A row counter or row-base register that drifts is caught at the first row boundary, because the first beat of the second row lands at the wrong address. A broken gate shows within the wait window as a beat issued while the selected rate line is low. A wrong error decode shows in the single cycle of the result strobe, together with beats or fetches that should never have happened.

// File: rtl/dseq_pkg.sv
// Shared constants and the descriptor type of the box-mode DMA sequencer.
package dseq_pkg;

    localparam int unsigned SINGLE_WORDS = 4;
    localparam int unsigned BOX_WORDS    = 6;
    localparam int unsigned MAX_WORDS    = 6;
    localparam int unsigned WORD_BYTES   = 4;

    localparam logic [2:0] CT_SINGLE = 3'd0;
    localparam logic [2:0] CT_BOX    = 3'd3;

    localparam int unsigned RES_VALID = 31;
    localparam int unsigned RES_ERR   = 3;
    localparam int unsigned RES_DONE  = 1;

    // One fetched descriptor; w3..w5 are length / count / offset words.
    typedef struct packed {
        logic [31:0] w5;
        logic [31:0] w4;
        logic [31:0] w3;
        logic [31:0] dst;
        logic [31:0] src;
        logic [31:0] cmd;
    } desc_t;

endpackage

// File: rtl/dseq_fetch.sv
// Descriptor loader: reads one descriptor (4 or 6 words, set by the type in
// the first word) through a request/response port with one read in flight.
// Assumes read data returns in order, after the grant.
module dseq_fetch #(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            restart,
    input  logic [AW-1:0]   base,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_gnt,
    input  logic            mem_rvalid,
    input  logic [31:0]     mem_rdata,
    output logic            done,
    output dseq_pkg::desc_t desc
);
    import dseq_pkg::*;

    logic [AW-1:0] ptr;
    logic [2:0]    idx;
    logic          active;
    logic          waiting;
    logic [31:0]   words [MAX_WORDS];
    logic [2:0]    type_now;
    logic          last_word;

    // Type of the descriptor being loaded (from the live word on the first read).
    always_comb begin
        type_now  = (idx == 3'd0) ? mem_rdata[2:0] : words[0][2:0];
        last_word = (idx == ((type_now == CT_BOX) ? 3'(BOX_WORDS - 1) : 3'(SINGLE_WORDS - 1)));
    end

    assign mem_req  = active && !waiting;
    assign mem_addr = ptr;

    // Request, capture and pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            idx     <= '0;
            active  <= 1'b0;
            waiting <= 1'b0;
            done    <= 1'b0;
            for (int i = 0; i < MAX_WORDS; i++) words[i] <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active  <= 1'b1;
                waiting <= 1'b0;
                idx     <= '0;
                if (restart) ptr <= base;
            end else if (active) begin
                if (!waiting) begin
                    if (mem_gnt) begin
                        waiting <= 1'b1;
                        ptr     <= ptr + AW'(WORD_BYTES);
                    end
                end else if (mem_rvalid) begin
                    words[idx] <= mem_rdata;
                    waiting    <= 1'b0;
                    if (last_word) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        idx <= idx + 3'd1;
                    end
                end
            end
        end
    end

    // Present the captured words as one descriptor.
    always_comb begin
        desc.cmd = words[0];
        desc.src = words[1];
        desc.dst = words[2];
        desc.w3  = words[3];
        desc.w4  = words[4];
        desc.w5  = words[5];
    end

    // R3: an ungranted request keeps its address.
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

endmodule

// File: rtl/dseq_gate.sv
// Rate-control gate: a row may start only when both selected request lines
// are high. Index 0 means ungated; index n selects line n-1.
module dseq_gate #(
    parameter int NREQ = 15
) (
    input  logic [3:0]      src_sel,
    input  logic [3:0]      dst_sel,
    input  logic [NREQ-1:0] req,
    output logic            ok
);
    logic src_ok;
    logic dst_ok;

    // Select each side's line; an index beyond NREQ never opens.
    always_comb begin
        src_ok = (src_sel == 4'd0);
        dst_ok = (dst_sel == 4'd0);
        for (int i = 0; i < NREQ; i++) begin
            if (src_sel == 4'(i + 1)) src_ok = req[i];
            if (dst_sel == 4'(i + 1)) dst_ok = req[i];
        end
        ok = src_ok && dst_ok;
    end

endmodule

// File: rtl/dseq_rows.sv
// Row engine: issues rows x beats address pairs. Each row waits for the gate,
// then runs to its end. Row starts advance by the per-side offsets.
// Assumes rows and beats are nonzero at start.
module dseq_rows #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [15:0]   rows,
    input  logic [15:0]   beats,
    input  logic [15:0]   src_step,
    input  logic [15:0]   dst_step,
    input  logic          gate_ok,
    output logic          beat_valid,
    input  logic          beat_ready,
    output logic [AW-1:0] beat_src,
    output logic [AW-1:0] beat_dst,
    output logic          done
);
    import dseq_pkg::*;

    logic          run;
    logic          in_row;
    logic [AW-1:0] row_src, row_dst, cur_src, cur_dst;
    logic [AW-1:0] s_step, d_step;
    logic [15:0]   beats_left, rows_left, row_beats;

    assign beat_valid = run && in_row;
    assign beat_src   = cur_src;
    assign beat_dst   = cur_dst;

    // Row wait, beat stepping and row advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run        <= 1'b0;
            in_row     <= 1'b0;
            done       <= 1'b0;
            row_src    <= '0;
            row_dst    <= '0;
            cur_src    <= '0;
            cur_dst    <= '0;
            s_step     <= '0;
            d_step     <= '0;
            beats_left <= '0;
            rows_left  <= '0;
            row_beats  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                run        <= 1'b1;
                in_row     <= 1'b0;
                row_src    <= src_base;
                row_dst    <= dst_base;
                cur_src    <= src_base;
                cur_dst    <= dst_base;
                s_step     <= AW'(src_step);
                d_step     <= AW'(dst_step);
                rows_left  <= rows;
                beats_left <= beats;
                row_beats  <= beats;
            end else if (run && !in_row) begin
                if (gate_ok) in_row <= 1'b1;
            end else if (run && beat_ready) begin
                if (beats_left == 16'd1) begin
                    in_row <= 1'b0;
                    if (rows_left == 16'd1) begin
                        run  <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        rows_left  <= rows_left - 16'd1;
                        beats_left <= row_beats;
                        row_src    <= row_src + s_step;
                        row_dst    <= row_dst + d_step;
                        cur_src    <= row_src + s_step;
                        cur_dst    <= row_dst + d_step;
                    end
                end else begin
                    beats_left <= beats_left - 16'd1;
                    cur_src    <= cur_src + AW'(WORD_BYTES);
                    cur_dst    <= cur_dst + AW'(WORD_BYTES);
                end
            end
        end
    end

    // R6: a row's first beat follows a cycle with the gate open.
    p_gate_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid) |-> $past(gate_ok));

    // R7: a stalled beat holds.
    p_beat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_src) && $stable(beat_dst));

endmodule

// File: rtl/box_dma_seq.sv
// Box-mode DMA command sequencer top: starts on a pointer write, fetches
// descriptors, checks them, runs each through the row engine and posts a
// result word. Assumes one list at a time; pointer writes while busy are dropped.
module box_dma_seq #(
    parameter int AW   = 32,
    parameter int NREQ = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ptr_wr,
    input  logic [AW-1:0]   ptr_data,
    output logic            busy,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_gnt,
    input  logic            mem_rvalid,
    input  logic [31:0]     mem_rdata,
    input  logic [NREQ-1:0] rate_req,
    output logic            beat_valid,
    input  logic            beat_ready,
    output logic [AW-1:0]   beat_src,
    output logic [AW-1:0]   beat_dst,
    output logic            result_valid,
    output logic [31:0]     result_word
);
    import dseq_pkg::*;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC} state_t;

    state_t st, st_nx;
    desc_t  desc;
    logic   f_go, f_restart, f_done;
    logic   e_start, e_done, gate_ok;
    logic   finish, fin_err;
    logic   is_single, is_box, bad, skip, last;
    logic [15:0] e_rows, e_beats, e_sstep, e_dstep;

    dseq_fetch #(.AW(AW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .go(f_go), .restart(f_restart),
        .base(ptr_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(f_done), .desc(desc)
    );

    dseq_gate #(.NREQ(NREQ)) u_gate (
        .src_sel(desc.cmd[6:3]), .dst_sel(desc.cmd[10:7]),
        .req(rate_req), .ok(gate_ok)
    );

    dseq_rows #(.AW(AW)) u_rows (
        .clk(clk), .rst_n(rst_n), .start(e_start),
        .src_base(AW'(desc.src)), .dst_base(AW'(desc.dst)),
        .rows(e_rows), .beats(e_beats), .src_step(e_sstep), .dst_step(e_dstep),
        .gate_ok(gate_ok), .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_src(beat_src), .beat_dst(beat_dst), .done(e_done)
    );

    // Decode and validate the fetched descriptor.
    always_comb begin
        is_single = (desc.cmd[2:0] == CT_SINGLE);
        is_box    = (desc.cmd[2:0] == CT_BOX);
        last      = desc.cmd[31];
        bad       = (|desc.cmd[30:11]) || (!is_single && !is_box)
                 || (is_single && (|desc.w3[31:16]))
                 || (is_box && ((desc.w4[31:16] == 16'd0) || (desc.w4[15:0] == 16'd0)
                              || (desc.w3[31:16] == 16'd0) || (desc.w3[31:16] != desc.w3[15:0])));
        skip      = is_single && (desc.w3[15:0] == 16'd0);
        e_rows    = is_box ? desc.w4[31:16] : 16'd1;
        e_beats   = is_box ? desc.w3[31:16] : desc.w3[15:0];
        e_sstep   = is_box ? desc.w5[31:16] : 16'd0;
        e_dstep   = is_box ? desc.w5[15:0]  : 16'd0;
    end

    // Sequencing: start, next fetch, execute, finish.
    always_comb begin
        st_nx     = st;
        f_go      = 1'b0;
        f_restart = 1'b0;
        e_start   = 1'b0;
        finish    = 1'b0;
        fin_err   = 1'b0;
        case (st)
            ST_IDLE: if (ptr_wr) begin
                if (|ptr_data[2:0]) begin
                    finish  = 1'b1;
                    fin_err = 1'b1;
                end else begin
                    f_go      = 1'b1;
                    f_restart = 1'b1;
                    st_nx     = ST_FETCH;
                end
            end
            ST_FETCH: if (f_done) begin
                if (bad) begin
                    finish  = 1'b1;
                    fin_err = 1'b1;
                end else if (skip) begin
                    if (last) finish = 1'b1;
                    else      f_go   = 1'b1;
                end else begin
                    e_start = 1'b1;
                    st_nx   = ST_EXEC;
                end
            end
            ST_EXEC: if (e_done) begin
                if (last) finish = 1'b1;
                else begin
                    f_go  = 1'b1;
                    st_nx = ST_FETCH;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
        if (finish) st_nx = ST_IDLE;
    end

    // State and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            result_valid <= 1'b0;
            result_word  <= '0;
        end else begin
            st           <= st_nx;
            result_valid <= finish;
            if (finish) begin
                result_word            <= '0;
                result_word[RES_VALID] <= 1'b1;
                result_word[RES_ERR]   <= fin_err;
                result_word[RES_DONE]  <= !fin_err;
            end
        end
    end

    assign busy = (st != ST_IDLE);

    // R8: result posts with busy already low and valid set.
    p_result_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> !busy && result_word[31]);

    // R8/R9: done and error are exclusive in a posted result.
    p_err_xor_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (result_word[3] != result_word[1]));

    // R2: descriptor reads only while busy.
    p_fetch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R2: beats only while busy.
    p_beat_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> busy);

endmodule

// File: tb/test_box_dma_seq.sv
`timescale 1ns/1ps
module test_box_dma_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_wr = 1'b0;
    logic [31:0] ptr_data = '0;
    logic        busy;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b1;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [14:0] rate_req = '0;
    logic        beat_valid;
    logic        beat_ready = 1'b1;
    logic [31:0] beat_src, beat_dst;
    logic        result_valid;
    logic [31:0] result_word;

    logic [31:0] mem [64];
    logic [31:0] bsrc [256];
    logic [31:0] bdst [256];
    int nb = 0, nfetch = 0, nres = 0, res_busy = 0, cyc = 0;
    int checks = 0, fails = 0;
    logic [31:0] last_res = '0;
    logic rdy_toggle = 1'b0;
    logic finished = 1'b0;

    box_dma_seq i_box_dma_seq (
        .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_data(ptr_data), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rate_req(rate_req),
        .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_src(beat_src),
        .beat_dst(beat_dst), .result_valid(result_valid), .result_word(result_word)
    );

    always #2.5 clk = ~clk;

    // Memory model: one-cycle read latency after grant.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req && mem_gnt) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[mem_addr[7:2]];
            nfetch     <= nfetch + 1;
        end
    end

    // Beat and result monitor.
    always @(posedge clk) begin
        if (beat_valid && beat_ready) begin
            bsrc[nb % 256] <= beat_src;
            bdst[nb % 256] <= beat_dst;
            nb <= nb + 1;
        end
        if (result_valid) begin
            nres     <= nres + 1;
            last_res <= result_word;
            if (busy) res_busy <= res_busy + 1;
        end
    end

    always @(negedge clk) beat_ready <= rdy_toggle ? ~beat_ready : 1'b1;

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000 && !finished) begin
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put4(input int a, input logic [31:0] w0, w1, w2, w3);
        mem[a/4] = w0; mem[a/4+1] = w1; mem[a/4+2] = w2; mem[a/4+3] = w3;
    endtask

    task automatic put6(input int a, input logic [31:0] w0, w1, w2, w3, w4, w5);
        put4(a, w0, w1, w2, w3);
        mem[a/4+4] = w4; mem[a/4+5] = w5;
    endtask

    task automatic kick(input logic [31:0] a);
        @(negedge clk); ptr_data = a; ptr_wr = 1'b1;
        @(negedge clk); ptr_wr = 1'b0;
    endtask

    task automatic wait_res(input int r0);
        int n = 0;
        while (nres == r0 && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic chk_beat(input string req, input int k, input logic [31:0] s, d);
        check(req, bsrc[k % 256], s);
        check(req, bdst[k % 256], d);
    endtask

    task automatic t_reset();
        check("R1 busy", 32'(busy), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        check("R1 beat_valid", 32'(beat_valid), 0);
        check("R1 result_valid", 32'(result_valid), 0);
    endtask

    task automatic t_single();
        int b0 = nb, f0 = nfetch, r0 = nres;
        put4(32'h00, 32'h8000_0000, 32'h1000, 32'h2000, 32'd3);
        kick(32'h00);
        check("R2 busy after write", 32'(busy), 1);
        wait_res(r0);
        check("R8 result", last_res, 32'h8000_0002);
        check("R8 busy low at result", 32'(res_busy), 0);
        check("R4 beat count", 32'(nb - b0), 3);
        for (int k = 0; k < 3; k++) chk_beat("R4 single", b0 + k, 32'h1000 + 4*k, 32'h2000 + 4*k);
        check("R3 fetch count", 32'(nfetch - f0), 4);
        @(negedge clk);
        check("R8 pulse ends", 32'(result_valid), 0);
    endtask

    task automatic chain_setup();
        put4(32'h20, 32'h0000_0000, 32'h1000, 32'h2000, 32'd2);
        put6(32'h30, 32'h8000_0003, 32'h3000, 32'h4000, 32'h0002_0002, 32'h0002_0002, 32'h0000_0010);
    endtask

    task automatic chain_check(input int b0, input string req);
        check(req, 32'(nb - b0), 6);
        chk_beat(req, b0 + 0, 32'h1000, 32'h2000);
        chk_beat(req, b0 + 1, 32'h1004, 32'h2004);
        chk_beat(req, b0 + 2, 32'h3000, 32'h4000);
        chk_beat(req, b0 + 3, 32'h3004, 32'h4004);
        chk_beat(req, b0 + 4, 32'h3000, 32'h4010);
        chk_beat(req, b0 + 5, 32'h3004, 32'h4014);
    endtask

    task automatic t_chain();
        int b0 = nb, f0 = nfetch, r0 = nres;
        chain_setup();
        kick(32'h20);
        wait_res(r0);
        chain_check(b0, "R5 box rows");
        check("R3 chained fetch", 32'(nfetch - f0), 10);
        check("R8 result", last_res, 32'h8000_0002);
    endtask

    task automatic t_zero_single();
        int b0 = nb, r0 = nres;
        put4(32'hA0, 32'h0000_0000, 32'h0, 32'h0, 32'd0);
        put4(32'hB0, 32'h8000_0000, 32'h7000, 32'h7100, 32'd1);
        kick(32'hA0);
        wait_res(r0);
        check("R4 zero length", 32'(nb - b0), 1);
        chk_beat("R4 after zero length", b0, 32'h7000, 32'h7100);
        check("R8 result", last_res, 32'h8000_0002);
    endtask

    task automatic t_gate();
        int b0 = nb, f0 = nfetch, r0 = nres;
        put6(32'h50, 32'h8000_002B, 32'h5000, 32'h6000, 32'h0001_0001, 32'h0002_0002, 32'h0008_0004);
        rate_req = '0;
        kick(32'h50);
        repeat (30) @(negedge clk);
        check("R6 no beat while gated", 32'(nb - b0), 0);
        check("R2 busy while gated", 32'(busy), 1);
        kick(32'h00);
        repeat (5) @(negedge clk);
        rate_req = 15'h0010;
        wait_res(r0);
        rate_req = '0;
        check("R6 beats after open", 32'(nb - b0), 2);
        chk_beat("R6 row 0", b0, 32'h5000, 32'h6000);
        chk_beat("R6 row 1", b0 + 1, 32'h5008, 32'h6004);
        check("R2 write while busy ignored", 32'(nfetch - f0), 6);
        check("R2 one result", 32'(nres - r0), 1);
        check("R8 result", last_res, 32'h8000_0002);
    endtask

    task automatic t_err_zero();
        int b0 = nb, f0 = nfetch, r0 = nres;
        put6(32'h68, 32'h0000_0003, 32'h1000, 32'h2000, 32'h0001_0001, 32'h0002_0000, 32'h0);
        put4(32'h80, 32'h8000_0000, 32'h1000, 32'h2000, 32'd1);
        kick(32'h68);
        wait_res(r0);
        check("R9 zero count result", last_res, 32'h8000_0008);
        check("R9 no beats", 32'(nb - b0), 0);
        check("R9 stops fetching", 32'(nfetch - f0), 6);
    endtask

    task automatic t_err_type();
        int b0 = nb, f0 = nfetch, r0 = nres;
        put4(32'h90, 32'h8000_0001, 32'h1000, 32'h2000, 32'd1);
        kick(32'h90);
        wait_res(r0);
        check("R9 bad type result", last_res, 32'h8000_0008);
        check("R9 bad type no beats", 32'(nb - b0), 0);
        check("R3 bad type fetch", 32'(nfetch - f0), 4);
    endtask

    task automatic t_misaligned();
        int f0 = nfetch, r0 = nres;
        kick(32'h24);
        wait_res(r0);
        check("R2 misaligned result", last_res, 32'h8000_0008);
        check("R2 misaligned no fetch", 32'(nfetch - f0), 0);
    endtask

    task automatic t_backpressure();
        int b0 = nb, r0 = nres;
        chain_setup();
        rdy_toggle = 1'b1;
        kick(32'h20);
        wait_res(r0);
        rdy_toggle = 1'b0;
        chain_check(b0, "R7 under backpressure");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single();
        t_chain();
        t_zero_single();
        t_gate();
        t_err_zero();
        t_err_type();
        t_misaligned();
        t_backpressure();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule